// File: doc/BRIEF.md
# Configuration Header Detector

This block sits on a serial configuration bit stream. The bits may come one per cycle from a byte fetcher that shifts each byte out from its low-order end, or they may come directly from a serial source. A `bit_valid` strobe qualifies every bit. The detector looks for the start-of-configuration header. That header is a run of ones, then a fixed four-bit preamble, then a 24-bit length count sent most significant bit first, then one or more dummy ones. A single zero ends the dummy bits and marks the start of the first data frame.

Once the header has been decoded, the block presents the length count and raises a level flag that says frame data has begun. It then counts the length down, one step for each further bit, and flags the end when the count reaches zero.

While the header is passing, every accepted bit is copied to an echo output one cycle later. This lets a probe on that pin see exactly what the detector consumed. From the first dummy bit onward, the echo output is held high. A malformed preamble, or a zero where the first dummy one belongs, raises a one-cycle error pulse, and the detector goes back to hunting for leading ones. The contents of the data frames are not interpreted.

Top module: `cfg_hdr_detect`

## Requirements
- R1: After reset, `echo_out` is 1, and `hdr_err`, `hdr_done`, `len_valid` and `frame_end` are 0, with `len_count` equal to 0.
- R2: Zero bits received before the first one bit are discarded without raising `hdr_err`. A run of one or more ones is accepted as the lead-in to the preamble.
- R3: The preamble must arrive as 0, 0, 1, 0 in that time order. If any preamble bit is wrong, `hdr_err` is high for exactly the one cycle after the offending bit, and the detector returns to hunting for ones. A complete header sent afterwards is decoded normally.
- R4: The 24 bits after the preamble form `len_count`, first-received bit in bit 23. `len_valid` rises after a correct first dummy bit and stays high with `len_count` unchanged until reset. The bytes FF 04 D0 42 F0, each shifted out from bit 0 to bit 7 and followed by a 0, decode to 0x00B420.
- R5: If the bit right after the 24th length bit is 0 rather than a dummy 1, `hdr_err` pulses, `len_valid` stays low, and the detector returns to hunting for ones.
- R6: `hdr_done` rises one cycle after the first 0 that follows the dummy ones, and stays high until reset.
- R7: Every accepted bit, up to and including the first dummy bit, appears on `echo_out` one cycle after it is accepted. For all later bits, `echo_out` is 1.
- R8: After the start bit, each valid bit lowers the remaining count by one. `frame_end` goes high once `len_count` bits have followed the start bit, or right after the start bit if the count is 0, and then stays high.
- R9: In a cycle with `bit_valid` low, `bit_in` has no effect: `len_count`, `echo_out`, `hdr_done` and `frame_end` keep their values, and `hdr_err` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial configuration bit |
| len_count | output | 24 | Captured length count |
| len_valid | output | 1 | Length count is complete and confirmed |
| hdr_done | output | 1 | Start bit seen; frame data is flowing |
| frame_end | output | 1 | Length countdown has reached zero |
| hdr_err | output | 1 | One-cycle pulse on a malformed header |
| echo_out | output | 1 | Delayed copy of header bits, then constant 1 |

## Verification
The hardest situations to reach from the ports are the exact end of the countdown and recovery after a bad preamble or dummy bit.

A realistic 24-bit length would need millions of data bits. The random headers therefore mostly draw counts below 64, and they include the zero count. This lets the bench watch `frame_end` stay low on the last bit before the end and rise on the end bit itself. A few large counts are checked for capture only.

Directed cases corrupt the second and the fourth preamble bit and the first dummy bit. Each case then sends a clean header, which shows that the detector went back to hunting. Idle gaps with a toggling `bit_in` are scattered through every phase.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    // Detector phases, in the order a well-formed header walks them
    typedef enum logic [2:0] {
        ST_HUNT,   // waiting for the first one bit
        ST_ONES,   // inside the run of leading ones
        ST_PRE,    // matching the remaining preamble bits
        ST_LEN,    // shifting in the length count
        ST_DUM1,   // expecting the first dummy one
        ST_DUM,    // extra dummy ones, waiting for the start bit
        ST_DATA    // frame data, counting down
    } hdr_st_e;

endpackage

// File: rtl/cfg_len_shift.sv
module cfg_len_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (shift_en) val_d = {val_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/cfg_len_down.sv
module cfg_len_down #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)                   rem_d = load_val;
        else if (dec && rem_q != 0) rem_d = rem_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign zero = (rem_q == '0);
endmodule

// File: rtl/cfg_pre_match.sv
module cfg_pre_match #(
    parameter int              PRE_W   = 4,
    parameter logic [PRE_W-1:0] PRE_PAT = 4'b0100,
    localparam int             PRE_IW  = $clog2(PRE_W)
) (
    input  logic [PRE_IW-1:0] idx,
    input  logic              bit_in,
    output logic              hit,
    output logic              last
);
    // PRE_PAT bit i holds the i-th preamble bit in arrival order
    assign hit  = (bit_in == PRE_PAT[idx]);
    assign last = (idx == PRE_IW'(PRE_W - 1));
endmodule

// File: rtl/cfg_hdr_detect.sv
module cfg_hdr_detect
    import cfg_hdr_pkg::*;
#(
    parameter int               LEN_W   = 24,
    parameter int               PRE_W   = 4,
    parameter logic [PRE_W-1:0] PRE_PAT = 4'b0100  // arrival order 0,0,1,0; bit 0 must be 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [LEN_W-1:0] len_count,
    output logic             len_valid,
    output logic             hdr_done,
    output logic             frame_end,
    output logic             hdr_err,
    output logic             echo_out
);
    localparam int PRE_IW = $clog2(PRE_W);
    localparam int LEN_IW = $clog2(LEN_W);

    typedef struct packed {
        hdr_st_e           st;
        logic [PRE_IW-1:0] pre_idx;
        logic [LEN_IW-1:0] len_idx;
        logic              echo;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic pre_hit, pre_last;
    logic len_shift, cnt_load, cnt_dec, cnt_zero;

    cfg_pre_match #(.PRE_W(PRE_W), .PRE_PAT(PRE_PAT)) u_pre (
        .idx    (ctl_q.pre_idx),
        .bit_in (bit_in),
        .hit    (pre_hit),
        .last   (pre_last)
    );

    cfg_len_shift #(.W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (len_shift),
        .bit_in   (bit_in),
        .value    (len_count)
    );

    cfg_len_down #(.W(LEN_W)) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (len_count),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        len_shift = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        if (bit_valid) begin
            // copy header bits; once past the first dummy the pin idles high
            ctl_d.echo = (ctl_q.st == ST_DUM || ctl_q.st == ST_DATA) ? 1'b1 : bit_in;
            case (ctl_q.st)
                ST_HUNT: begin
                    if (bit_in) ctl_d.st = ST_ONES;
                end
                ST_ONES: begin
                    if (!bit_in) begin
                        ctl_d.st      = ST_PRE;
                        ctl_d.pre_idx = PRE_IW'(1);
                    end
                end
                ST_PRE: begin
                    if (!pre_hit) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_HUNT;
                    end else if (pre_last) begin
                        ctl_d.st      = ST_LEN;
                        ctl_d.len_idx = '0;
                    end else begin
                        ctl_d.pre_idx = ctl_q.pre_idx + PRE_IW'(1);
                    end
                end
                ST_LEN: begin
                    len_shift = 1'b1;
                    if (ctl_q.len_idx == LEN_IW'(LEN_W - 1)) ctl_d.st = ST_DUM1;
                    else ctl_d.len_idx = ctl_q.len_idx + LEN_IW'(1);
                end
                ST_DUM1: begin
                    if (bit_in) ctl_d.st = ST_DUM;
                    else begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_HUNT;
                    end
                end
                ST_DUM: begin
                    if (!bit_in) begin
                        ctl_d.st = ST_DATA;
                        cnt_load = 1'b1;
                    end
                end
                ST_DATA: begin
                    cnt_dec = !cnt_zero;
                end
                default: ctl_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_HUNT;
            ctl_q.pre_idx <= '0;
            ctl_q.len_idx <= '0;
            ctl_q.echo    <= 1'b1;
            ctl_q.err     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign len_valid = (ctl_q.st == ST_DUM) || (ctl_q.st == ST_DATA);
    assign hdr_done  = (ctl_q.st == ST_DATA);
    assign frame_end = hdr_done && cnt_zero;
    assign hdr_err   = ctl_q.err;
    assign echo_out  = ctl_q.echo;
endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic [LEN_W-1:0] len_count,
    input logic             len_valid,
    input logic             hdr_done,
    input logic             frame_end,
    input logic             hdr_err,
    input logic             echo_out
);
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) hdr_err |=> !hdr_err); // R3
    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) len_valid |=> (len_valid && $stable(len_count))); // R4
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n) hdr_done |=> hdr_done); // R6
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) hdr_done |-> (len_valid && !hdr_err)); // R6
    AST_ECHO_HIGH: assert property (@(posedge clk) disable iff (!rst_n) hdr_done |-> echo_out); // R7
    AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) frame_end |-> hdr_done); // R8
    AST_END_HELD: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> frame_end); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> ($stable(len_count) && $stable(echo_out) && $stable(hdr_done)
                        && $stable(frame_end) && !hdr_err)); // R9
endmodule

bind cfg_hdr_detect cfg_hdr_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .len_count (len_count),
    .len_valid (len_valid),
    .hdr_done  (hdr_done),
    .frame_end (frame_end),
    .hdr_err   (hdr_err),
    .echo_out  (echo_out)
);

// File: tb/cfg_hdr_detect_test.sv
module cfg_hdr_detect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic [23:0] len_count;
    logic        len_valid, hdr_done, frame_end, hdr_err, echo_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cfg_hdr_detect uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .len_count(len_count), .len_valid(len_valid), .hdr_done(hdr_done),
        .frame_end(frame_end), .hdr_err(hdr_err), .echo_out(echo_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Idle cycles with a toggling bit_in: nothing may move (R9)
    task automatic idle(input int n);
        logic [23:0] l0 = len_count;
        logic e0 = echo_out, d0 = hdr_done, f0 = frame_end;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_valid = 1'b0; bit_in = ~bit_in;
            @(posedge clk); #1;
        end
        chk(len_count == l0 && echo_out == e0 && hdr_done == d0 && frame_end == f0 && !hdr_err,
            "R9 idle hold", {len_count, echo_out, hdr_done, frame_end, hdr_err},
            {l0, e0, d0, f0, 1'b0});
    endtask

    task automatic send(input logic b);
        if ($urandom % 6 == 0) idle(1 + $urandom % 2);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(posedge clk); #1;
        bit_valid = 1'b0; bit_in = $urandom % 2;
    endtask

    task automatic send_echo(input logic b, input logic exp_echo);
        send(b);
        chk(echo_out == exp_echo, "R7 echo", echo_out, exp_echo);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bit_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(echo_out && !hdr_err && !hdr_done && !len_valid && !frame_end && len_count == 0,
            "R1 reset state", {len_count, echo_out, hdr_err, hdr_done, len_valid, frame_end},
            {24'h0, 5'b10000});
    endtask

    // Send lead-in ones, preamble and length count (echo checked per bit)
    task automatic lead_and_len(input int n1, input logic [23:0] lc);
        for (int i = 0; i < n1; i++) send_echo(1'b1, 1'b1);
        send_echo(1'b0, 1'b0); send_echo(1'b0, 1'b0);
        send_echo(1'b1, 1'b1); send_echo(1'b0, 1'b0);
        for (int i = 23; i >= 0; i--) send_echo(lc[i], lc[i]);
    endtask

    // Full header: ones, preamble, count, dummies, start bit
    task automatic header(input int n1, input logic [23:0] lc, input int nd);
        lead_and_len(n1, lc);
        send_echo(1'b1, 1'b1);
        chk(len_valid && len_count == lc, "R4 length capture", len_count, lc);
        for (int i = 1; i < nd; i++) send_echo(1'b1, 1'b1);
        chk(!hdr_done, "R6 not done during dummies", hdr_done, 0);
        send_echo(1'b0, 1'b1);
        chk(hdr_done, "R6 done after start bit", hdr_done, 1);
        chk(frame_end == (lc == 0), "R8 end after start", frame_end, lc == 0);
    endtask

    task automatic data_phase(input logic [23:0] lc);
        int n = (lc > 64) ? 10 : int'(lc);
        for (int i = 0; i < n; i++) begin
            chk(!frame_end, "R8 end not early", frame_end, 0);
            send_echo(1'($urandom % 2), 1'b1);
        end
        chk(frame_end == (lc <= 64), "R8 end at count", frame_end, lc <= 64);
        send_echo(1'b0, 1'b1);
        chk(frame_end == (lc <= 64) && len_count == lc, "R8 end held", frame_end, lc <= 64);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0] bytes [5];
        void'($urandom(32'h5EED1234));
        bytes[0] = 8'hFF; bytes[1] = 8'h04; bytes[2] = 8'hD0; bytes[3] = 8'h42; bytes[4] = 8'hF0;

        // R4: byte example, each byte shifted out from bit 0
        do_reset();
        for (int k = 0; k < 5; k++)
            for (int j = 0; j < 8; j++) send(bytes[k][j]);
        chk(len_valid && len_count == 24'h00B420, "R4 byte example", len_count, 24'h00B420);
        send(1'b0);
        chk(hdr_done, "R6 byte example done", hdr_done, 1);

        // R2: zeros before any one are ignored
        do_reset();
        for (int i = 0; i < 5; i++) begin
            send_echo(1'b0, 1'b0);
            chk(!hdr_err, "R2 leading zero no error", hdr_err, 0);
        end
        header(1, 24'd5, 1);
        data_phase(24'd5);

        // R3: bad second preamble bit, then recovery
        do_reset();
        send(1'b1); send(1'b1); send(1'b0); send(1'b1);
        chk(hdr_err, "R3 error pulse", hdr_err, 1);
        send(1'b1);
        chk(!hdr_err, "R3 error one cycle", hdr_err, 0);
        header(2, 24'h00ABCD, 2);

        // R3: bad fourth preamble bit
        do_reset();
        send(1'b1); send(1'b0); send(1'b0); send(1'b1); send(1'b1);
        chk(hdr_err, "R3 error on last preamble bit", hdr_err, 1);
        header(3, 24'd2, 1);
        data_phase(24'd2);

        // R5: zero where the first dummy belongs
        do_reset();
        lead_and_len(2, 24'h123456);
        send(1'b0);
        chk(hdr_err && !len_valid, "R5 dummy error", {hdr_err, len_valid}, 2'b10);
        header(1, 24'd0, 3);
        data_phase(24'd0);

        // Random headers
        for (int it = 0; it < 30; it++) begin
            logic [23:0] lc = ($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 64);
            do_reset();
            for (int z = 0; z < int'($urandom % 3); z++) send_echo(1'b0, 1'b0);
            header(1 + $urandom % 6, lc, 1 + $urandom % 4);
            data_phase(lc);
        end

        report();
    end
endmodule